// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from four on-chip event sources and five external pins and latches each one into its own request flag. Every flag has an enable bit, and a single master enable gates all vectored delivery. The flags are grouped into five vector slots with a fixed resolution order. While the master enable is set, the highest-ranked slot that has an enabled, pending flag is presented to the processor as an interrupt request with a vector table address. When the processor acknowledges, the block records the slot as in service. It clears the flag if that flag is the slot's only member, and it drops the master enable.

Software can pick one slot as the privileged slot through a priority field in the control word. Accepting the privileged slot leaves the master enable set. While an ordinary slot is in service and software has turned the master enable back on, only the privileged slot may cut in. Nesting stops at two levels. A return strobe pops one level and turns the master enable back on. Two test pins set flags on a rising edge and take part in standby wake-up, but they never cause a vector. External pins pass through a synchronizer before edge detection. Software reads and writes the flags, the enables and the control word through a small register port.

Top module: `prio_vec_intc`

## Requirements
- R1: The flag register holds these bits: bit 0 tick, bit 1 both-edge pin, bit 2 selectable-edge pin, bit 3 rising pin, bit 4 serial-done, bit 5 timer 0, bit 6 timer 1, bit 7 test pin A, bit 8 test pin B. An internal source that is high at a rising clock edge sets its flag at that edge.
- R2: A change on an external pin sets its flag at the third rising clock edge after the change. The both-edge pin reacts to both edges. The rising pin and the test pins react to rising edges only.
- R3: Control bit 1 selects the active edge of the selectable-edge pin: 0 for rising, 1 for falling. The other edge sets nothing.
- R4: `irq_o` is high only when some flag, its enable bit and the master enable (control bit 0) are all set. `vector_o` then equals 0x0002 + 2 × slot, and it is 0 when `irq_o` is low.
- R5: The slots, in descending priority, are 0 {tick, both-edge pin}, 1 {selectable-edge pin}, 2 {rising pin}, 3 {serial-done}, 4 {timer 0, timer 1}. The highest pending eligible slot is the one presented.
- R6: An acknowledge (`ack_i` while `irq_o` is high) clears the flag of a slot that has a single member. The flags of the two shared slots are left set.
- R7: An acknowledge clears the master enable unless the accepted slot equals the priority field (control bits 4:2; a value of 5 or more selects no slot). An acknowledge overrides a write to the master enable in the same cycle.
- R8: At nesting depth 1 only the privileged slot may be presented, and only if the in-service slot is a different slot. At depth 2 nothing is presented.
- R9: `ret_i` at a non-zero depth, in a cycle with no acknowledge, lowers the depth by one and sets the master enable.
- R10: The test flags (bits 7 and 8) never cause `irq_o`.
- R11: `wake_o` is high whenever any flag has its enable bit set, including the test flags, whatever the state of the master enable.
- R12: A write to address 0 replaces the flags. A flag set by a source in the same cycle stays set.
- R13: The register map is address 0 flags, 1 enables, 2 control {priority[4:2], edge[1], master enable[0]}, 3 reads zero. Reads are combinational. After reset, flags, enables and the master enable are 0, the edge bit is 0 and the priority field is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Interval tick pulse (flag bit 0) |
| sio_done_i | input | 1 | Serial transfer end pulse (flag bit 4) |
| tmr0_i | input | 1 | Timer 0 match pulse (flag bit 5) |
| tmr1_i | input | 1 | Timer 1 match pulse (flag bit 6) |
| pin_both_i | input | 1 | External pin, both edges (flag bit 1) |
| pin_sel_i | input | 1 | External pin, selectable edge (flag bit 2) |
| pin_rise_i | input | 1 | External pin, rising edge (flag bit 3) |
| test_a_i | input | 1 | Test pin A, rising edge (flag bit 7) |
| test_b_i | input | 1 | Test pin B, rising edge (flag bit 8) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data |
| ack_i | input | 1 | Processor accepts the presented vector |
| ret_i | input | 1 | Return from the current service level |
| irq_o | output | 1 | Vectored interrupt request |
| vector_o | output | DATA_W | Vector table address |
| wake_o | output | 1 | Standby release request |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, a nesting limit of two, a vector base of 2 and a step of 2. With these values the three-edge pin latency can be counted exactly, and the nesting limit is reached after two acknowledges. The stimulus table places flag, enable and master-enable patterns against the fixed slot order, including shared slots that have only one member enabled. Directed sequences then cover edge selection, acknowledge clearing, the privileged-slot preemption at depth 1, the blocking at depth 2, return, and a flag that is set in the same cycle as a software clear.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NUM_FLAGS = 9;
  localparam int unsigned NUM_SLOTS = 5;
  localparam int unsigned NUM_PINS  = 5;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS + 1);

  // flag bit positions
  localparam int unsigned F_TICK = 0;
  localparam int unsigned F_SIO  = 4;
  localparam int unsigned F_TMR0 = 5;
  localparam int unsigned F_TMR1 = 6;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_BOTH = 2'd1,
    EDGE_SEL  = 2'd2
  } edge_mode_e;

  // membership of each vector slot, slot 0 ranks highest
  localparam logic [NUM_FLAGS-1:0] SLOT_MASK [NUM_SLOTS] =
    '{9'h003, 9'h004, 9'h008, 9'h010, 9'h060};

  // external pins: index -> flag bit and edge mode
  localparam int unsigned PIN_FLAG [NUM_PINS] = '{1, 2, 3, 7, 8};
  localparam edge_mode_e  PIN_MODE [NUM_PINS] =
    '{EDGE_BOTH, EDGE_SEL, EDGE_RISE, EDGE_RISE, EDGE_RISE};

  localparam logic [1:0] ADDR_FLAGS = 2'd0;
  localparam logic [1:0] ADDR_EN    = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;

  function automatic logic slot_single(input int unsigned s);
    return ($countones(SLOT_MASK[s]) == 1);
  endfunction
endpackage

// File: rtl/pic_edge_sync.sv
module pic_edge_sync #(
  parameter int unsigned         STAGES = 2,
  parameter pic_pkg::edge_mode_e MODE   = pic_pkg::EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;
  logic              cur, rise, fall, use_rise, use_fall;

  always_comb begin
    sync_d    = sync_q << 1;
    sync_d[0] = pin_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur  = sync_q[STAGES-1];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    case (MODE)
      pic_pkg::EDGE_BOTH: begin use_rise = 1'b1;        use_fall = 1'b1;       end
      pic_pkg::EDGE_SEL:  begin use_rise = ~fall_sel_i; use_fall = fall_sel_i; end
      default:            begin use_rise = 1'b1;        use_fall = 1'b0;       end
    endcase
  end

  assign pulse_o = (rise & use_rise) | (fall & use_fall);

  // R2: a detected edge is a single-cycle pulse
  p_pulse_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o) else $error("edge pulse held two cycles");
endmodule

// File: rtl/pic_flag_bank.sv
module pic_flag_bank #(
  parameter int unsigned NF = pic_pkg::NUM_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] ack_clr_i,
  input  logic          wr_flags_i,
  input  logic          wr_en_i,
  input  logic [NF-1:0] wdata_i,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] en_o
);
  logic [NF-1:0] flags_q, flags_d, en_q, en_d;

  always_comb begin
    flags_d = flags_q;
    if (wr_flags_i) flags_d = wdata_i;
    flags_d = (flags_d & ~ack_clr_i) | set_i;
    en_d = en_q;
    if (wr_en_i) en_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;

  // R12: a source pulse always lands, whatever the write did
  p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)))
    else $error("source set lost");

  // R6: acknowledge clearing takes effect when no set collides
  p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|ack_clr_i) && !(|(ack_clr_i & set_i))) |=> ((flags_q & $past(ack_clr_i)) == '0))
    else $error("acknowledged flag not cleared");
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  input  logic [NUM_SLOTS-1:0] gate_i,
  output logic                 valid_o,
  output logic [SLOT_W-1:0]    slot_o
);
  logic [NUM_SLOTS-1:0] elig;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign elig[s] = (|(flags_i & en_i & SLOT_MASK[s])) & gate_i[s];
  end

  always_comb begin
    valid_o = 1'b0;
    slot_o  = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (elig[s]) begin
        valid_o = 1'b1;
        slot_o  = SLOT_W'(s);
      end
    end
  end

  // R5: no higher-ranked eligible slot is passed over
  always_comb begin
    if (valid_o) begin
      a_highest_r5: assert ((elig & ~({NUM_SLOTS{1'b1}} << slot_o)) == '0)
        else $error("lower slot won arbitration");
    end
  end
endmodule

// File: rtl/pic_nest_ctrl.sv
module pic_nest_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned MAX_DEPTH = 2,
  localparam int unsigned DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ack_i,
  input  logic               ret_i,
  input  logic [SLOT_W-1:0]  acc_slot_i,
  input  logic [SLOT_W-1:0]  prio_slot_i,
  input  logic               ime_wr_i,
  input  logic               ime_wdata_i,
  output logic               ime_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [SLOT_W-1:0]  cur_slot_o
);
  logic               ime_q, ime_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic [SLOT_W-1:0]  stack_q [MAX_DEPTH];
  logic [SLOT_W-1:0]  stack_d [MAX_DEPTH];
  logic               push, pop;

  assign push = ack_i && (depth_q < DEPTH_W'(MAX_DEPTH));
  assign pop  = !push && ret_i && (depth_q != '0);

  always_comb begin
    ime_d   = ime_q;
    depth_d = depth_q;
    stack_d = stack_q;
    if (ime_wr_i) ime_d = ime_wdata_i;
    if (push) begin
      for (int i = 0; i < MAX_DEPTH; i++) begin
        if (DEPTH_W'(i) == depth_q) stack_d[i] = acc_slot_i;
      end
      depth_d = depth_q + DEPTH_W'(1);
      ime_d   = (acc_slot_i == prio_slot_i);
    end else if (pop) begin
      depth_d = depth_q - DEPTH_W'(1);
      ime_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ime_q   <= 1'b0;
      depth_q <= '0;
      for (int i = 0; i < MAX_DEPTH; i++) stack_q[i] <= '0;
    end else begin
      ime_q   <= ime_d;
      depth_q <= depth_d;
      stack_q <= stack_d;
    end
  end

  always_comb begin
    cur_slot_o = '1;
    for (int i = 0; i < MAX_DEPTH; i++) begin
      if (DEPTH_W'(i + 1) == depth_q) cur_slot_o = stack_q[i];
    end
  end

  assign ime_o   = ime_q;
  assign depth_o = depth_q;

  p_depth_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= DEPTH_W'(MAX_DEPTH)) else $error("nesting depth overrun");

  p_ack_drops_ime_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && (acc_slot_i != prio_slot_i)) |=> !ime_q)
    else $error("master enable survived ordinary acknowledge");

  p_ret_restores_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (ime_q && (depth_q == $past(depth_q) - DEPTH_W'(1))))
    else $error("return did not pop a level");
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pic_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_DEPTH   = 2,
  parameter int unsigned VEC_BASE    = 2,
  parameter int unsigned VEC_STEP    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sio_done_i,
  input  logic              tmr0_i,
  input  logic              tmr1_i,
  input  logic              pin_both_i,
  input  logic              pin_sel_i,
  input  logic              pin_rise_i,
  input  logic              test_a_i,
  input  logic              test_b_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] vector_o,
  output logic              wake_o
);
  localparam int unsigned DEPTH_W = $clog2(MAX_DEPTH + 1);

  logic [NUM_PINS-1:0]  pins, pin_pulse;
  logic [NUM_FLAGS-1:0] set_vec, ack_clr, flags, en;
  logic [NUM_SLOTS-1:0] gate;
  logic                 wr_flags, wr_en_bits, wr_ctrl;
  logic                 edge_fall_q, edge_fall_d;
  logic [SLOT_W-1:0]    prio_q, prio_d;
  logic                 ime;
  logic [DEPTH_W-1:0]   depth;
  logic [SLOT_W-1:0]    cur_slot, arb_slot;
  logic                 arb_valid, ack_ok;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_FLAGS];

  // register decode
  assign wr_flags   = wr_en_i && (addr_i == ADDR_FLAGS);
  assign wr_en_bits = wr_en_i && (addr_i == ADDR_EN);
  assign wr_ctrl    = wr_en_i && (addr_i == ADDR_CTRL);

  always_comb begin
    edge_fall_d = edge_fall_q;
    prio_d      = prio_q;
    if (wr_ctrl) begin
      edge_fall_d = wdata_i[1];
      prio_d      = wdata_i[2 +: SLOT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_fall_q <= 1'b0;
      prio_q      <= '1;
    end else begin
      edge_fall_q <= edge_fall_d;
      prio_q      <= prio_d;
    end
  end

  // external pins
  assign pins = {test_b_i, test_a_i, pin_rise_i, pin_sel_i, pin_both_i};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pic_edge_sync #(
      .STAGES (SYNC_STAGES),
      .MODE   (PIN_MODE[p])
    ) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pins[p]),
      .fall_sel_i (edge_fall_q),
      .pulse_o    (pin_pulse[p])
    );
  end

  always_comb begin
    set_vec         = '0;
    set_vec[F_TICK] = tick_i;
    set_vec[F_SIO]  = sio_done_i;
    set_vec[F_TMR0] = tmr0_i;
    set_vec[F_TMR1] = tmr1_i;
    for (int p = 0; p < NUM_PINS; p++) set_vec[PIN_FLAG[p]] = pin_pulse[p];
  end

  // acknowledge: clear the flag of a single-member slot
  assign ack_ok = ack_i && irq_o;

  always_comb begin
    ack_clr = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (ack_ok && (arb_slot == SLOT_W'(s)) && slot_single(s)) ack_clr = SLOT_MASK[s];
    end
  end

  pic_flag_bank #(.NF(NUM_FLAGS)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .ack_clr_i  (ack_clr),
    .wr_flags_i (wr_flags),
    .wr_en_i    (wr_en_bits),
    .wdata_i    (wdata_i[NUM_FLAGS-1:0]),
    .flags_o    (flags),
    .en_o       (en)
  );

  // which slots may be presented at the current nesting level
  always_comb begin
    gate = '0;
    if (depth == '0) begin
      gate = '1;
    end else if ((depth < DEPTH_W'(MAX_DEPTH)) && (prio_q < SLOT_W'(NUM_SLOTS))
                 && (cur_slot != prio_q)) begin
      gate[prio_q] = 1'b1;
    end
  end

  pic_arbiter u_arb (
    .flags_i (flags),
    .en_i    (en),
    .gate_i  (gate),
    .valid_o (arb_valid),
    .slot_o  (arb_slot)
  );

  pic_nest_ctrl #(.MAX_DEPTH(MAX_DEPTH)) u_nest (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_ok),
    .ret_i       (ret_i),
    .acc_slot_i  (arb_slot),
    .prio_slot_i (prio_q),
    .ime_wr_i    (wr_ctrl),
    .ime_wdata_i (wdata_i[0]),
    .ime_o       (ime),
    .depth_o     (depth),
    .cur_slot_o  (cur_slot)
  );

  assign irq_o    = ime && arb_valid;
  assign vector_o = irq_o ? (DATA_W'(VEC_BASE) + DATA_W'(arb_slot) * DATA_W'(VEC_STEP)) : '0;
  assign wake_o   = |(flags & en);

  always_comb begin
    case (addr_i)
      ADDR_FLAGS: rdata_o = DATA_W'(flags);
      ADDR_EN:    rdata_o = DATA_W'(en);
      ADDR_CTRL:  rdata_o = DATA_W'({prio_q, edge_fall_q, ime});
      default:    rdata_o = '0;
    endcase
  end

  p_full_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth == DEPTH_W'(MAX_DEPTH)) |-> !irq_o) else $error("request at full depth");

  p_irq_wakes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o) else $error("request without wake");

  p_test_no_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(flags & en & SLOT_MASK[arb_slot]))) else $error("vector from test flag");
endmodule

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, sio, tm0, tm1, pboth, psel, prise, ta, tb;
  logic        wr_en, ack, ret;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata, vec;
  logic        irq, wake;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  prio_vec_intc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sio_done_i(sio), .tmr0_i(tm0),
    .tmr1_i(tm1), .pin_both_i(pboth), .pin_sel_i(psel), .pin_rise_i(prise),
    .test_a_i(ta), .test_b_i(tb), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ack_i(ack), .ret_i(ret), .irq_o(irq), .vector_o(vec), .wake_o(wake)
  );

  // {flags[38:30], en[29:21], ime[20], prio[19:17], exp_irq[16], exp_vec[15:0]}
  localparam logic [38:0] TBL [8] = '{
    {9'h004, 9'h004, 1'b1, 3'd7, 1'b1, 16'h0004},
    {9'h004, 9'h000, 1'b1, 3'd7, 1'b0, 16'h0000},
    {9'h004, 9'h004, 1'b0, 3'd7, 1'b0, 16'h0000},
    {9'h07F, 9'h1FF, 1'b1, 3'd7, 1'b1, 16'h0002},
    {9'h078, 9'h1FF, 1'b1, 3'd7, 1'b1, 16'h0006},
    {9'h060, 9'h040, 1'b1, 3'd7, 1'b1, 16'h000A},
    {9'h180, 9'h1FF, 1'b1, 3'd7, 1'b0, 16'h0000},
    {9'h012, 9'h010, 1'b1, 3'd7, 1'b1, 16'h0008}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0;
    {tick, sio, tm0, tm1, pboth, psel, prise, ta, tb} = '0;
    {wr_en, ack, ret} = '0;
    addr = '0; wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // reset state, R13
    rd(2'd0, d); chk("R13 reset flags", d, 16'h0000);
    rd(2'd2, d); chk("R13 reset ctrl", d, 16'h001C);
    chk("R13 reset irq", irq, 0);
    chk("R13 reset wake", wake, 0);

    // table walk: gating R4, order R5, test flags R10
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, {7'd0, TBL[i][29:21]});
      wr(2'd2, {11'd0, TBL[i][19:17], 1'b0, TBL[i][20]});
      wr(2'd0, {7'd0, TBL[i][38:30]});
      chk($sformatf("R4/R5 row %0d irq", i), irq, TBL[i][16]);
      chk($sformatf("R4/R5 row %0d vector", i), vec, TBL[i][15:0]);
    end
    wr(2'd0, 16'h0); wr(2'd2, 16'h001C); wr(2'd1, 16'h01FF);

    // R1 internal pulses
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    rd(2'd0, d); chk("R1 tick sets bit 0", d, 16'h0001);
    @(negedge clk); sio = 1'b1; tm1 = 1'b1; @(negedge clk); sio = 1'b0; tm1 = 1'b0;
    rd(2'd0, d); chk("R1 serial and timer 1 bits", d, 16'h0051);
    chk("R11 wake with master enable off", wake, 1);
    chk("R4 no irq with master enable off", irq, 0);
    wr(2'd0, 16'h0);

    // R2 pin latency and edge sense
    @(negedge clk); prise = 1'b1; cyc(2);
    rd(2'd0, d); chk("R2 rising pin not yet", d, 16'h0000);
    cyc(1);
    rd(2'd0, d); chk("R2 rising pin at third edge", d, 16'h0008);
    wr(2'd0, 16'h0);
    @(negedge clk); prise = 1'b0; cyc(4);
    rd(2'd0, d); chk("R2 rising pin ignores fall", d, 16'h0000);
    @(negedge clk); pboth = 1'b1; cyc(3);
    rd(2'd0, d); chk("R2 both-edge pin rise", d, 16'h0002);
    wr(2'd0, 16'h0);
    @(negedge clk); pboth = 1'b0; cyc(3);
    rd(2'd0, d); chk("R2 both-edge pin fall", d, 16'h0002);
    wr(2'd0, 16'h0);

    // R3 selectable edge
    wr(2'd2, 16'h001E);
    @(negedge clk); psel = 1'b1; cyc(4);
    rd(2'd0, d); chk("R3 falling mode ignores rise", d, 16'h0000);
    @(negedge clk); psel = 1'b0; cyc(3);
    rd(2'd0, d); chk("R3 falling mode sets on fall", d, 16'h0004);
    wr(2'd0, 16'h0); wr(2'd2, 16'h001C);

    // R10 / R11 test pins
    @(negedge clk); ta = 1'b1; cyc(3);
    rd(2'd0, d); chk("R10 test pin sets bit 7", d, 16'h0080);
    chk("R11 test flag wakes", wake, 1);
    wr(2'd2, 16'h001D);
    chk("R10 test flag gives no irq", irq, 0);
    wr(2'd0, 16'h0);
    chk("R11 wake drops with no flag", wake, 0);
    @(negedge clk); ta = 1'b0; cyc(4);

    // R6 / R7 / R9 acknowledge and return
    wr(2'd0, 16'h0004);
    chk("R4 slot 1 irq", irq, 1);
    chk("R4 slot 1 vector", vec, 16'h0004);
    do_ack();
    rd(2'd0, d); chk("R6 single slot flag cleared", d, 16'h0000);
    rd(2'd2, d); chk("R7 master enable dropped", d, 16'h001C);
    do_ret();
    rd(2'd2, d); chk("R9 return sets master enable", d, 16'h001D);
    wr(2'd0, 16'h0001);
    chk("R5 slot 0 vector", vec, 16'h0002);
    do_ack();
    rd(2'd0, d); chk("R6 shared slot flag kept", d, 16'h0001);
    chk("R7 no irq after acknowledge", irq, 0);
    do_ret();
    chk("R9 irq again after return", irq, 1);
    wr(2'd0, 16'h0);

    // R8 nesting with privileged slot 1
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'h0010);
    chk("R5 slot 3 vector", vec, 16'h0008);
    do_ack();
    wr(2'd0, 16'h0005);
    chk("R8 no preempt while master enable off", irq, 0);
    wr(2'd2, 16'h0005);
    chk("R8 privileged slot preempts", irq, 1);
    chk("R8 privileged vector over slot 0", vec, 16'h0004);
    do_ack();
    rd(2'd2, d); chk("R7 privileged accept keeps master enable", d, 16'h0005);
    rd(2'd0, d); chk("R6 privileged flag cleared", d, 16'h0001);
    wr(2'd0, 16'h0005);
    chk("R8 nothing at depth 2", irq, 0);
    do_ret();
    chk("R9 depth 1 privileged again", vec, 16'h0004);
    do_ret();
    chk("R9 depth 0 highest slot", vec, 16'h0002);
    wr(2'd2, 16'h001C); wr(2'd0, 16'h0);

    // R12 set beats clear in same cycle
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 16'h0;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(2'd0, d); chk("R12 set wins over write", d, 16'h0001);

    // R13 map
    rd(2'd1, d); chk("R13 enable readback", d, 16'h01FF);
    rd(2'd3, d); chk("R13 address 3 reads zero", d, 16'h0000);

    finish_run();
  end
endmodule